// File: doc/BRIEF.md
# Oscillator Trim Recovery Controller

This block holds an on-chip RC oscillator at its target frequency. It counts oscillator ticks during the interval between two successive synchronization events and compares that count with a programmed expected value. It then moves a 7-bit trim code toward the value that cancels the difference. The synchronization pulse can come from one of four inputs: a USB start-of-frame strobe, a 1 MHz clock divided from an external crystal, a 32.768 kHz crystal clock, or a general-purpose pin. The chosen pulse passes through a two-flop synchronizer, an edge selector and a power-of-two prescaler.

Each measurement window yields a signed error, and the error selects a correction class. A small error moves the trim by one step and a medium error moves it by two. A large error, or a window that overruns its bound, leaves the trim unchanged and raises an error. Sticky flags record the outcome, and a maskable interrupt line reports it. Software can switch the loop to manual mode and write the trim directly. A standby-exit pulse restores the factory trim and restarts calibration.

Top module: `osc_trim_ctrl`

## Requirements
- R1: After reset, `trim_code` equals `factory_trim`, and `status_flags`, `dir_fast` and `irq` are all zero.
- R2: `src_sel` chooses the sync input: 0 USB start-of-frame, 1 the 1 MHz reference, 2 the low-speed crystal clock, 3 the pin. Pulses on the other inputs have no effect on the trim or the flags.
- R3: Each sync input passes through a two-flop synchronizer. An edge counts as a sync edge only when it matches `sync_pol`: 0 selects rising edges and 1 selects falling edges.
- R4: Only one sync edge in every 2^`sync_div` becomes an accepted sync event. The prescaler restarts whenever `cal_en` is low.
- R5: Each accepted event reloads a 16-bit window counter with `reload_val`. The ticks in the cycle of the event itself are not counted. The first event after enabling, after a missed window or after standby exit only starts a window. Every later event evaluates the error e = (ticks counted) − `reload_val`.
- R6: When |e| is 0 there is no trim change. When 0 < |e| ≤ `fine_lim` the trim moves by one step. Both cases set the sync-OK flag (bit 0 of `status_flags`).
- R7: When `fine_lim` < |e| ≤ `warn_lim` the trim moves by two steps and sync-OK is set. When `warn_lim` < |e| ≤ `err_lim` the trim moves by two steps and the warning flag (bit 1) is set.
- R8: When |e| > `err_lim` the trim does not change and the error flag (bit 2) is set. If e reaches `err_lim`+1 before the next event, the window is abandoned: bits 2 and 3 (missed) are set, and the next event only restarts the window.
- R9: When e > 0 (oscillator fast) the trim steps down; when e < 0 it steps up. `dir_fast` latches 1 for a fast result and 0 for a slow one at every evaluation.
- R10: The trim saturates at 0 and at 127 and never wraps.
- R11: When `auto_en` is 0, evaluations leave the trim alone and a `sw_trim_wr` pulse loads `sw_trim_val`. When `auto_en` is 1, `sw_trim_wr` is ignored.
- R12: A `standby_exit` pulse loads `factory_trim` into the trim and disarms the window counter.
- R13: Flags stay set until the matching bit of `flag_clr` is pulsed. `irq` is high while any of flag bits 0 to 2 is set together with the same bit of `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_exit | input | 1 | Pulse: restore factory trim and disarm |
| osc_tick | input | 1 | One-cycle strobe per oscillator-derived tick |
| sync_sof | input | 1 | USB start-of-frame sync input (asynchronous) |
| sync_ref1m | input | 1 | 1 MHz divided external reference (asynchronous) |
| sync_lse | input | 1 | 32.768 kHz crystal clock sync input (asynchronous) |
| sync_pin | input | 1 | External pin sync input (asynchronous) |
| cal_en | input | 1 | Enables the measurement loop |
| auto_en | input | 1 | 1 automatic trim, 0 manual trim |
| src_sel | input | 2 | Sync source select |
| sync_pol | input | 1 | 0 rising, 1 falling edge |
| sync_div | input | 3 | Sync prescaler exponent |
| reload_val | input | 16 | Expected ticks per window |
| fine_lim | input | 8 | Fine-step limit |
| warn_lim | input | 8 | Warning limit |
| err_lim | input | 8 | Error limit |
| factory_trim | input | 7 | Factory trim value |
| sw_trim_wr | input | 1 | Software trim write strobe |
| sw_trim_val | input | 7 | Software trim value |
| flag_clr | input | 4 | Per-flag clear pulses |
| irq_en | input | 3 | Interrupt enables for OK, warning, error |
| trim_code | output | 7 | Oscillator trim code |
| status_flags | output | 4 | {missed, error, warning, sync-OK} |
| dir_fast | output | 1 | Last evaluated direction, 1 = fast |
| irq | output | 1 | Interrupt request |

## Verification
The bench places sync pulses a known number of cycles apart, so each window holds an exact tick count. It chooses errors on each class boundary: zero, the fine limit, the coarse band, the warning band and beyond the error limit. A design that compares with the wrong inequality would take the wrong step size or raise the wrong flag. Other tests drive the trim against both ends of its range, where an unsaturated adder would wrap to the far end. A polarity test uses pulses whose rising and falling edges are spaced differently, so a design that detects the wrong edge measures a different error. The bench also overruns a window and then sends two more pulses. A design that evaluates the stale window after a miss, or that fails to restart, would move the trim at the wrong event.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

    localparam int TRIM_W  = 7;
    localparam int CNT_W   = 16;
    localparam int LIM_W   = 8;
    localparam int DIV_W   = 3;
    localparam int NUM_SRC = 4;
    localparam int SEL_W   = $clog2(NUM_SRC);
    localparam int PRE_W   = (1 << DIV_W) - 1;
    localparam int FLAG_W  = 4;
    localparam int IRQ_W   = 3;
    localparam logic [TRIM_W-1:0] TRIM_MAX = {TRIM_W{1'b1}};

    typedef enum logic [SEL_W-1:0] {
        SRC_SOF   = 2'd0,
        SRC_REF1M = 2'd1,
        SRC_LSE   = 2'd2,
        SRC_PIN   = 2'd3
    } sync_src_e;

    typedef enum logic [2:0] {
        CLS_ZERO   = 3'd0,
        CLS_FINE   = 3'd1,
        CLS_COARSE = 3'd2,
        CLS_WARN   = 3'd3,
        CLS_ERR    = 3'd4
    } err_class_e;

    // Result of one measurement window, presented in the cycle of the event.
    typedef struct packed {
        logic             valid;
        logic             fast;
        logic [CNT_W-1:0] mag;
    } window_t;

    // Bit order: miss = 3, err = 2, warn = 1, ok = 0.
    typedef struct packed {
        logic miss;
        logic err;
        logic warn;
        logic ok;
    } flags_t;

    function automatic err_class_e classify(
        input logic [CNT_W-1:0] mag,
        input logic [LIM_W-1:0] fine,
        input logic [LIM_W-1:0] warn,
        input logic [LIM_W-1:0] err
    );
        if (mag == '0)                    return CLS_ZERO;
        else if (mag <= CNT_W'(fine))     return CLS_FINE;
        else if (mag <= CNT_W'(warn))     return CLS_COARSE;
        else if (mag <= CNT_W'(err))      return CLS_WARN;
        else                              return CLS_ERR;
    endfunction

    function automatic logic [1:0] class_step(input err_class_e cls);
        case (cls)
            CLS_FINE:             return 2'd1;
            CLS_COARSE, CLS_WARN: return 2'd2;
            default:              return 2'd0;
        endcase
    endfunction

    function automatic logic [TRIM_W-1:0] sat_step(
        input logic [TRIM_W-1:0] cur,
        input logic [1:0]        step,
        input logic              down
    );
        logic [TRIM_W:0] wide;
        if (down) begin
            if (cur < TRIM_W'(step)) return '0;
            return cur - TRIM_W'(step);
        end
        wide = {1'b0, cur} + (TRIM_W+1)'(step);
        if (wide > {1'b0, TRIM_MAX}) return TRIM_MAX;
        return wide[TRIM_W-1:0];
    endfunction

endpackage

// File: rtl/trim_sync_front.sv
module trim_sync_front
    import osc_trim_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en_i,
    input  logic               clr_i,
    input  logic [NUM_SRC-1:0] lines_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               pol_i,
    input  logic [DIV_W-1:0]   div_i,
    output logic               evt_o
);

    logic [NUM_SRC-1:0] synced;

    // Two-flop synchronizer on every candidate sync line.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
        logic [1:0] sr_q;
        always_ff @(posedge clk) begin
            if (rst) sr_q <= '0;
            else     sr_q <= {sr_q[0], lines_i[i]};
        end
        assign synced[i] = sr_q[1];
    end

    logic cur_lvl;
    logic prev_q;
    logic edge_hit;
    assign cur_lvl  = synced[sel_i];
    assign edge_hit = pol_i ? (prev_q & ~cur_lvl) : (cur_lvl & ~prev_q);

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= cur_lvl;
    end

    // Power-of-two prescaler: accept the edge that completes a group.
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_mask;
    assign pre_mask = ~({PRE_W{1'b1}} << div_i);
    assign evt_o    = en_i && !clr_i && edge_hit && ((pre_q & pre_mask) == pre_mask);

    always_ff @(posedge clk) begin
        if (rst || !en_i || clr_i) pre_q <= '0;
        else if (edge_hit)         pre_q <= pre_q + 1'b1;
    end

endmodule

// File: rtl/trim_window_cnt.sv
module trim_window_cnt
    import osc_trim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic             evt_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [LIM_W-1:0] err_lim_i,
    output window_t          win_o,
    output logic             miss_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             passed_q;
    logic             armed_q;
    logic             frozen_q;

    logic run;
    logic at_bound;
    assign run      = en_i && !clr_i && armed_q && !frozen_q;
    assign at_bound = passed_q && (cnt_q >= CNT_W'(err_lim_i));
    assign miss_o   = run && !evt_i && tick_i && at_bound;

    // cnt_q holds the distance from the expected count; passed_q its sign.
    assign win_o.valid = run && evt_i;
    assign win_o.fast  = passed_q;
    assign win_o.mag   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i || clr_i) begin
            cnt_q    <= '0;
            passed_q <= 1'b0;
            armed_q  <= 1'b0;
            frozen_q <= 1'b0;
        end else if (evt_i) begin
            cnt_q    <= reload_i;
            passed_q <= 1'b0;
            armed_q  <= 1'b1;
            frozen_q <= 1'b0;
        end else if (run && tick_i) begin
            if (!passed_q) begin
                if (cnt_q == '0) begin
                    passed_q <= 1'b1;
                    cnt_q    <= CNT_W'(1);
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end else if (at_bound) begin
                frozen_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/trim_adjust.sv
module trim_adjust
    import osc_trim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic [TRIM_W-1:0] factory_i,
    input  logic              auto_i,
    input  logic              sw_wr_i,
    input  logic [TRIM_W-1:0] sw_val_i,
    input  window_t           win_i,
    input  logic [LIM_W-1:0]  fine_i,
    input  logic [LIM_W-1:0]  warn_i,
    input  logic [LIM_W-1:0]  err_i,
    output logic [TRIM_W-1:0] trim_o,
    output err_class_e        cls_o
);

    logic [1:0]        step;
    logic [TRIM_W-1:0] stepped;

    assign cls_o   = classify(win_i.mag, fine_i, warn_i, err_i);
    assign step    = class_step(cls_o);
    assign stepped = sat_step(trim_o, step, win_i.fast);

    always_ff @(posedge clk) begin
        if (rst || clr_i)              trim_o <= factory_i;
        else if (!auto_i && sw_wr_i)   trim_o <= sw_val_i;
        else if (auto_i && win_i.valid) trim_o <= stepped;
    end

endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl
    import osc_trim_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               standby_exit,
    input  logic               osc_tick,
    input  logic               sync_sof,
    input  logic               sync_ref1m,
    input  logic               sync_lse,
    input  logic               sync_pin,
    input  logic               cal_en,
    input  logic               auto_en,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic               sync_pol,
    input  logic [DIV_W-1:0]   sync_div,
    input  logic [CNT_W-1:0]   reload_val,
    input  logic [LIM_W-1:0]   fine_lim,
    input  logic [LIM_W-1:0]   warn_lim,
    input  logic [LIM_W-1:0]   err_lim,
    input  logic [TRIM_W-1:0]  factory_trim,
    input  logic               sw_trim_wr,
    input  logic [TRIM_W-1:0]  sw_trim_val,
    input  logic [FLAG_W-1:0]  flag_clr,
    input  logic [IRQ_W-1:0]   irq_en,
    output logic [TRIM_W-1:0]  trim_code,
    output logic [FLAG_W-1:0]  status_flags,
    output logic               dir_fast,
    output logic               irq
);

    logic       evt;
    window_t    win;
    logic       miss_pulse;
    err_class_e cls;
    logic       win_valid;
    logic       win_fast;

    trim_sync_front u_front (
        .clk     (clk),
        .rst     (rst),
        .en_i    (cal_en),
        .clr_i   (standby_exit),
        .lines_i ({sync_pin, sync_lse, sync_ref1m, sync_sof}),
        .sel_i   (src_sel),
        .pol_i   (sync_pol),
        .div_i   (sync_div),
        .evt_o   (evt)
    );

    trim_window_cnt u_window (
        .clk       (clk),
        .rst       (rst),
        .en_i      (cal_en),
        .clr_i     (standby_exit),
        .evt_i     (evt),
        .tick_i    (osc_tick),
        .reload_i  (reload_val),
        .err_lim_i (err_lim),
        .win_o     (win),
        .miss_o    (miss_pulse)
    );

    trim_adjust u_adjust (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (standby_exit),
        .factory_i (factory_trim),
        .auto_i    (auto_en),
        .sw_wr_i   (sw_trim_wr),
        .sw_val_i  (sw_trim_val),
        .win_i     (win),
        .fine_i    (fine_lim),
        .warn_i    (warn_lim),
        .err_i     (err_lim),
        .trim_o    (trim_code),
        .cls_o     (cls)
    );

    assign win_valid = win.valid;
    assign win_fast  = win.fast;

    flags_t flags_q;
    flags_t flags_set;

    always_comb begin
        flags_set      = '0;
        flags_set.ok   = win_valid && (cls == CLS_ZERO || cls == CLS_FINE || cls == CLS_COARSE);
        flags_set.warn = win_valid && (cls == CLS_WARN);
        flags_set.err  = (win_valid && (cls == CLS_ERR)) || miss_pulse;
        flags_set.miss = miss_pulse;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_t'((FLAG_W'(flags_q) & ~flag_clr) | FLAG_W'(flags_set));
    end

    always_ff @(posedge clk) begin
        if (rst)            dir_fast <= 1'b0;
        else if (win_valid) dir_fast <= win_fast;
    end

    assign status_flags = FLAG_W'(flags_q);
    assign irq          = |(status_flags[IRQ_W-1:0] & irq_en);

endmodule

// File: rtl/osc_trim_ctrl_chk.sv
module osc_trim_ctrl_chk
    import osc_trim_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              standby_exit,
    input logic              auto_en,
    input logic              sw_trim_wr,
    input logic [TRIM_W-1:0] factory_trim,
    input logic [TRIM_W-1:0] trim_code,
    input logic [FLAG_W-1:0] status_flags,
    input logic              win_valid,
    input logic              win_fast,
    input logic              miss_pulse,
    input err_class_e        cls
);

    // R12: standby exit restores the factory trim on the next cycle.
    assert_standby_restore_R12: assert property (@(posedge clk) disable iff (rst)
        standby_exit |=> (trim_code == $past(factory_trim)));

    // R11: in manual mode the trim only moves on a software write.
    assert_manual_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!auto_en && !sw_trim_wr && !standby_exit) |=> $stable(trim_code));

    // R7: one automatic correction never exceeds two steps.
    assert_step_bound_R7: assert property (@(posedge clk) disable iff (rst)
        (auto_en && !standby_exit) |=>
            ((int'(trim_code) - int'($past(trim_code)) <= 2) &&
             (int'($past(trim_code)) - int'(trim_code) <= 2)));

    // R8: a missed window raises both error and missed flags.
    assert_miss_flags_R8: assert property (@(posedge clk) disable iff (rst)
        miss_pulse |=> (status_flags[2] && status_flags[3]));

    // R8: an out-of-limit window leaves the trim unchanged.
    assert_err_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (win_valid && cls == CLS_ERR && auto_en && !standby_exit) |=> $stable(trim_code));

    // R10: at full scale a slow result does not wrap the trim.
    assert_sat_top_R10: assert property (@(posedge clk) disable iff (rst)
        (win_valid && !win_fast && auto_en && !standby_exit && trim_code == TRIM_MAX)
            |=> (trim_code == TRIM_MAX));

    // R10: at zero a fast result does not wrap the trim.
    assert_sat_bottom_R10: assert property (@(posedge clk) disable iff (rst)
        (win_valid && win_fast && auto_en && !standby_exit && trim_code == '0)
            |=> (trim_code == '0));

endmodule

bind osc_trim_ctrl osc_trim_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .standby_exit (standby_exit),
    .auto_en      (auto_en),
    .sw_trim_wr   (sw_trim_wr),
    .factory_trim (factory_trim),
    .trim_code    (trim_code),
    .status_flags (status_flags),
    .win_valid    (win_valid),
    .win_fast     (win_fast),
    .miss_pulse   (miss_pulse),
    .cls          (cls)
);

// File: tb/osc_trim_ctrl_bench.sv
module osc_trim_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       standby_exit;
    logic       osc_tick;
    logic [3:0] lines;
    logic       cal_en;
    logic       auto_en;
    logic [1:0] src_sel;
    logic       sync_pol;
    logic [2:0] sync_div;
    logic [15:0] reload_val;
    logic [7:0] fine_lim, warn_lim, err_lim;
    logic [6:0] factory_trim;
    logic       sw_trim_wr;
    logic [6:0] sw_trim_val;
    logic [3:0] flag_clr;
    logic [2:0] irq_en;
    logic [6:0] trim_code;
    logic [3:0] status_flags;
    logic       dir_fast;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    osc_trim_ctrl u_osc_trim_ctrl (
        .clk(clk), .rst(rst), .standby_exit(standby_exit), .osc_tick(osc_tick),
        .sync_sof(lines[0]), .sync_ref1m(lines[1]), .sync_lse(lines[2]), .sync_pin(lines[3]),
        .cal_en(cal_en), .auto_en(auto_en), .src_sel(src_sel), .sync_pol(sync_pol),
        .sync_div(sync_div), .reload_val(reload_val), .fine_lim(fine_lim),
        .warn_lim(warn_lim), .err_lim(err_lim), .factory_trim(factory_trim),
        .sw_trim_wr(sw_trim_wr), .sw_trim_val(sw_trim_val), .flag_clr(flag_clr),
        .irq_en(irq_en), .trim_code(trim_code), .status_flags(status_flags),
        .dir_fast(dir_fast), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Raise a line for hi cycles; the next pulse may start gap cycles after this one.
    task automatic pulse_at(input int line, input int hi, input int gap);
        lines[line] = 1'b1;
        cycles(hi);
        lines[line] = 1'b0;
        cycles(gap - hi);
    endtask

    // Two rising edges n cycles apart: the window holds n-1 ticks.
    task automatic pair(input int line, input int n);
        pulse_at(line, 2, n);
        pulse_at(line, 2, 10);
    endtask

    task automatic restart();
        cal_en   = 1'b0;
        flag_clr = 4'hF;
        cycles(1);
        flag_clr = 4'h0;
        cal_en   = 1'b1;
        cycles(1);
    endtask

    task automatic sw_write(input int val);
        sw_trim_val = 7'(val);
        sw_trim_wr  = 1'b1;
        cycles(1);
        sw_trim_wr  = 1'b0;
        cycles(1);
    endtask

    task automatic t_reset();
        check("R1 trim", trim_code, 64);
        check("R1 flags", status_flags, 0);
        check("R1 irq", irq, 0);
        check("R1 dir", dir_fast, 0);
    endtask

    task automatic t_fine_fast();
        restart();
        pair(0, 103);                        // e = +2
        check("R6 fine step down", trim_code, 63);
        check("R6 ok flag", status_flags, 4'b0001);
        check("R9 dir fast", dir_fast, 1);
    endtask

    task automatic t_coarse_slow();
        restart();
        pair(0, 97);                         // e = -4
        check("R7 coarse step up", trim_code, 65);
        check("R7 ok flag", status_flags, 4'b0001);
        check("R9 dir slow", dir_fast, 0);
    endtask

    task automatic t_warn();
        restart();
        pair(0, 109);                        // e = +8
        check("R7 warn step", trim_code, 63);
        check("R7 warn flag", status_flags, 4'b0010);
    endtask

    task automatic t_err_slow();
        restart();
        pair(0, 86);                         // e = -15
        check("R8 err hold", trim_code, 63);
        check("R8 err flag", status_flags, 4'b0100);
    endtask

    task automatic t_miss();
        restart();
        pulse_at(0, 2, 150);                 // window overruns
        check("R8 miss flags", status_flags, 4'b1100);
        check("R8 miss hold", trim_code, 63);
        pulse_at(0, 2, 10);                  // only restarts
        check("R5 restart no eval", status_flags, 4'b1100);
        check("R5 restart trim", trim_code, 63);
        cycles(93);
        pulse_at(0, 2, 10);                  // 103 after restart: e = +2
        check("R5 eval after restart", trim_code, 62);
        check("R5 ok after restart", status_flags, 4'b1101);
    endtask

    task automatic t_zero();
        restart();
        pair(0, 101);                        // e = 0
        check("R6 zero no step", trim_code, 62);
        check("R6 zero ok", status_flags, 4'b0001);
    endtask

    task automatic t_manual();
        restart();
        auto_en = 1'b0;
        sw_write(126);
        check("R11 manual write", trim_code, 126);
        pair(0, 97);
        check("R11 manual no auto step", trim_code, 126);
        check("R11 manual flags", status_flags, 4'b0001);
    endtask

    task automatic t_sat_high();
        restart();
        auto_en = 1'b1;
        pair(0, 97);                         // +2 from 126
        check("R10 clamp high", trim_code, 127);
        sw_write(5);
        check("R11 auto ignores write", trim_code, 127);
    endtask

    task automatic t_sat_low();
        restart();
        auto_en = 1'b0;
        sw_write(1);
        auto_en = 1'b1;
        restart();
        pair(0, 105);                        // e = +4, -2 from 1
        check("R10 clamp low", trim_code, 0);
    endtask

    task automatic t_source();
        restart();
        src_sel = 2'd2;
        pair(0, 97);
        check("R2 unselected trim", trim_code, 0);
        check("R2 unselected flags", status_flags, 0);
        pair(2, 97);
        check("R2 selected lse", trim_code, 2);
    endtask

    task automatic t_polarity();
        restart();
        src_sel  = 2'd0;
        sync_pol = 1'b1;
        pulse_at(0, 2, 88);
        pulse_at(0, 12, 20);                 // falls 98 apart: e = -3
        check("R3 falling edge", trim_code, 4);
    endtask

    task automatic t_prescale();
        sync_pol = 1'b0;
        sync_div = 3'd1;
        restart();
        for (int k = 0; k < 4; k++) pulse_at(0, 2, 51);  // events 102 apart: e = +1
        check("R4 prescale", trim_code, 3);
        check("R4 prescale flag", status_flags, 4'b0001);
        sync_div = 3'd0;
    endtask

    task automatic t_irq();
        restart();
        irq_en = 3'b010;
        pair(0, 109);                        // e = +8
        check("R13 warn step", trim_code, 1);
        check("R13 irq set", irq, 1);
        flag_clr = 4'b0010;
        cycles(1);
        flag_clr = 4'b0000;
        cycles(1);
        check("R13 flag cleared", status_flags, 0);
        check("R13 irq low", irq, 0);
    endtask

    task automatic t_standby();
        standby_exit = 1'b1;
        cycles(1);
        standby_exit = 1'b0;
        cycles(1);
        check("R12 factory restore", trim_code, 64);
        pulse_at(0, 2, 10);
        check("R12 disarmed flags", status_flags, 0);
        check("R12 disarmed trim", trim_code, 64);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1; standby_exit = 1'b0; osc_tick = 1'b1; lines = '0;
        cal_en = 1'b0; auto_en = 1'b1; src_sel = 2'd0; sync_pol = 1'b0;
        sync_div = 3'd0; reload_val = 16'd100; fine_lim = 8'd2; warn_lim = 8'd5;
        err_lim = 8'd10; factory_trim = 7'd64; sw_trim_wr = 1'b0; sw_trim_val = '0;
        flag_clr = '0; irq_en = '0;
        cycles(4);
        rst = 1'b0;
        cycles(2);
        t_reset();
        t_fine_fast();
        t_coarse_slow();
        t_warn();
        t_err_slow();
        t_miss();
        t_zero();
        t_manual();
        t_sat_high();
        t_sat_low();
        t_source();
        t_polarity();
        t_prescale();
        t_irq();
        t_standby();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule